// File: doc/BRIEF.md
# Two-Stage Cascaded Watchdog Timer

This block is a watchdog built from two chained down-counters, a low stage and a high stage, each `STAGE_W` bits wide (8 by default, 16 bits in all). A prescaler divides the input clock by `2**PRE_LOG2` (16 by default). Every prescaler tick steps the low stage. The high stage steps either on each low-stage underflow (long range) or directly on each prescaler tick (short range). When the high stage underflows, the block raises a one-cycle internal reset request. The reset circuit outside the block then asserts `rst` to bring the whole device back, this block included.

Software sees a single 8-bit control register. After reset the counters are held. The first write of any value starts them, and every later write reloads both stages, which is how the running program services the watchdog. Data bit 7 picks the range. Data bit 6 is a sticky lock. Once the lock is set, a stop-mode request from the CPU is turned into a reset request instead of being allowed. A read returns the two control bits beside the upper six bits of the live high stage.

Top module: `wdog_cascade`

## Requirements
- R1: While `rst` is high, and after it falls, both stages hold all ones, the range bit and the lock are 0, the counters are stopped, `reg_rdata` reads 0x3F and `wdt_rst_req` is 0.
- R2: Until the first control write after reset, neither stage changes, however long the block waits. Any write value starts counting, which then continues until the next reset.
- R3: A control write reloads both stages to all ones and restarts the prescaler. A high-stage underflow that falls in the same cycle as a write raises no request, so a write made before the timeout delays the request by a full period counted from that write.
- R4: The low stage steps down once every `2**PRE_LOG2` cycles while running. It wraps from 0 to all ones and gives a one-cycle underflow strobe on the wrap.
- R5: With bit 7 written as 1, the high stage steps on every prescaler tick. `wdt_rst_req` is high in exactly the 256·D-th cycle after the write edge (D = 2**PRE_LOG2), and not earlier.
- R6: With bit 7 written as 0, the high stage steps on every low-stage underflow. `wdt_rst_req` is high in exactly the 65536·D-th cycle after the write edge.
- R7: The request is a single-cycle pulse, and each one comes from a high-stage underflow or from a locked stop request. After the pulse the high stage wraps to all ones and goes on counting.
- R8: If `stop_req` is high at a clock edge while the lock is 1, `wdt_rst_req` is high for the following cycle. While the lock is 0, `stop_req` has no effect on the request or on the register.
- R9: A write with data bit 6 = 1 sets the lock. Later writes with bit 6 = 0 leave it set, and only `rst` clears it.
- R10: `reg_rdata` bit 7 is the range select, bit 6 is the lock, and bits 5:0 are high stage bits 7:2. It follows the state with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the prescaler input |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Write data (bit 7 range, bit 6 lock) |
| reg_rdata | output | 8 | Read view of control bits and high stage |
| stop_req | input | 1 | Stop-mode request from the CPU |
| wdt_rst_req | output | 1 | One-cycle internal reset request |

## Verification
The bench sets the divide to 2 (D = 2), so the short range times out on the 512th edge after the write edge and the long range on the 131072nd. The bench counts edges from the write edge and samples one nanosecond after each edge. At that point it checks for no pulse on edge N-1, a pulse on edge N, and no pulse again on N+1. `reg_rdata` is combinational, so it is sampled right after the edge that updates the stage. A locked stop request is driven before an edge and its pulse is expected right after that edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int RD_W    = 8;
    localparam int FIELD_W = 6;

    typedef struct packed {
        logic src_tick;   // 1: high stage steps on prescaler tick
        logic stop_lock;  // sticky stop-to-reset lock
    } wdog_ctrl_t;

    localparam wdog_ctrl_t CTRL_RESET = '{src_tick: 1'b0, stop_lock: 1'b0};

    function automatic logic [RD_W-1:0] pack_view(wdog_ctrl_t c, logic [FIELD_W-1:0] hi_top);
        return {c.src_tick, c.stop_lock, hi_top};
    endfunction

    function automatic wdog_ctrl_t merge_write(wdog_ctrl_t old, logic [1:0] wbits);
        wdog_ctrl_t n;
        n.src_tick  = wbits[1];
        n.stop_lock = old.stop_lock | wbits[0];
        return n;
    endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int PRE_LOG2 = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    logic [PRE_LOG2-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    assign tick = &cnt_q;
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage #(
    parameter int STAGE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               step,
    output logic [STAGE_W-1:0] value,
    output logic               uflow
);
    logic [STAGE_W-1:0] val_q;

    always_ff @(posedge clk) begin
        if (rst || load) val_q <= '1;
        else if (step)   val_q <= val_q - 1'b1;
    end

    assign value = val_q;
    assign uflow = step && (val_q == '0);
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [1:0] wbits,
    output wdog_ctrl_t ctrl,
    output logic       running
);
    wdog_ctrl_t ctrl_q;
    logic       run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            run_q  <= 1'b0;
        end else if (wr) begin
            ctrl_q <= merge_write(ctrl_q, wbits);
            run_q  <= 1'b1;
        end
    end

    assign ctrl    = ctrl_q;
    assign running = run_q;
endmodule

// File: rtl/wdog_cascade.sv
module wdog_cascade
    import wdog_pkg::*;
#(
    parameter int STAGE_W  = 8,
    parameter int PRE_LOG2 = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  logic [RD_W-1:0] reg_wdata,
    output logic [RD_W-1:0] reg_rdata,
    input  logic            stop_req,
    output logic            wdt_rst_req
);
    localparam int TOP_LSB = STAGE_W - FIELD_W;

    wdog_ctrl_t         ctrl;
    logic               run;
    logic               tick;
    logic [STAGE_W-1:0] lo_val, hi_val;
    logic               lo_uf, hi_uf;
    logic               lo_step, hi_step;
    logic               req_q;
    logic               unused_wdata;

    assign unused_wdata = ^reg_wdata[FIELD_W-1:0];

    wdog_ctrl u_ctrl (
        .clk(clk), .rst(rst), .wr(reg_wr),
        .wbits(reg_wdata[RD_W-1:RD_W-2]),
        .ctrl(ctrl), .running(run)
    );

    wdog_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
        .clk(clk), .rst(rst), .restart(reg_wr), .tick(tick)
    );

    assign lo_step = run && tick;
    assign hi_step = run && (ctrl.src_tick ? tick : lo_uf);

    wdog_stage #(.STAGE_W(STAGE_W)) u_lo (
        .clk(clk), .rst(rst), .load(reg_wr), .step(lo_step),
        .value(lo_val), .uflow(lo_uf)
    );

    wdog_stage #(.STAGE_W(STAGE_W)) u_hi (
        .clk(clk), .rst(rst), .load(reg_wr), .step(hi_step),
        .value(hi_val), .uflow(hi_uf)
    );

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= (hi_uf && !reg_wr) || (stop_req && ctrl.stop_lock);
    end

    assign wdt_rst_req = req_q;
    assign reg_rdata   = pack_view(ctrl, hi_val[STAGE_W-1:TOP_LSB]);
endmodule

// File: rtl/wdog_cascade_chk.sv
module wdog_cascade_chk #(
    parameter int STAGE_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               wr,
    input logic               stop_req,
    input logic               lock,
    input logic               run,
    input logic [STAGE_W-1:0] hi,
    input logic [STAGE_W-1:0] lo,
    input logic               lo_uf,
    input logic               hi_uf,
    input logic               req,
    input logic [7:0]         rdata
);
    a_r2_held_until_write: assert property (@(posedge clk) disable iff (rst)
        !run |-> (hi == '1 && lo == '1));

    a_r3_write_reloads: assert property (@(posedge clk) disable iff (rst)
        wr |=> (hi == '1 && lo == '1));

    a_r4_low_strobe_single: assert property (@(posedge clk) disable iff (rst)
        lo_uf |=> !lo_uf);

    a_r7_pulse_cause: assert property (@(posedge clk) disable iff (rst)
        req |-> $past((hi_uf && !wr) || (stop_req && lock)));

    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        rdata[6] |=> rdata[6]);
endmodule

bind wdog_cascade wdog_cascade_chk #(.STAGE_W(STAGE_W)) u_chk (
    .clk(clk), .rst(rst), .wr(reg_wr), .stop_req(stop_req),
    .lock(ctrl.stop_lock), .run(run), .hi(hi_val), .lo(lo_val),
    .lo_uf(lo_uf), .hi_uf(hi_uf), .req(wdt_rst_req), .rdata(reg_rdata)
);

// File: tb/test_wdog_cascade.sv
module test_wdog_cascade;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       stop_req = 1'b0;
    logic       wdt_rst_req;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    wdog_cascade #(.STAGE_W(8), .PRE_LOG2(1)) i_wdog_cascade (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .stop_req(stop_req), .wdt_rst_req(wdt_rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    // write captured at the next edge; returns 1ns after that edge
    task automatic do_write(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    // advance n edges, return number of request pulses seen
    task automatic run_count(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (wdt_rst_req) pulses++;
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 read after reset", reg_rdata, 8'h3F);
        chk("R1 request low", wdt_rst_req, 1'b0);
    endtask

    task automatic t_stopped();
        int p;
        run_count(700, p);
        chk("R2 no pulse while stopped", p, 0);
        chk("R2 stage held while stopped", reg_rdata, 8'h3F);
    endtask

    task automatic t_stop_unlocked();
        int p;
        do_write(8'h00);
        stop_req = 1'b1;
        run_count(3, p);
        stop_req = 1'b0;
        chk("R8 unlocked stop ignored", p, 0);
        chk("R8 register untouched", reg_rdata, 8'h3F);
    endtask

    task automatic t_short_range();
        int p;
        do_reset();
        do_write(8'h80);
        chk("R10 read after range write", reg_rdata, 8'hBF);
        run_count(8, p);
        chk("R5 high stage stepped 4", reg_rdata, 8'hBE);
        run_count(511 - 8, p);
        chk("R5 no early pulse", p, 0);
        run_count(1, p);
        chk("R5 pulse at 512", p, 1);
        run_count(1, p);
        chk("R7 pulse one cycle", p, 0);
        chk("R7 high stage wrapped", reg_rdata, 8'hBF);
    endtask

    task automatic t_kick();
        int p;
        do_reset();
        do_write(8'h80);
        run_count(300, p);
        do_write(8'h80);
        run_count(511, p);
        chk("R3 kick delays request", p, 0);
        run_count(1, p);
        chk("R3 pulse full period after kick", p, 1);
    endtask

    task automatic t_lock();
        int p;
        do_reset();
        do_write(8'h40);
        chk("R9 lock set", reg_rdata, 8'h7F);
        do_write(8'h00);
        chk("R9 lock survives zero write", reg_rdata, 8'h7F);
        stop_req = 1'b1;
        @(posedge clk); #1;
        stop_req = 1'b0;
        chk("R8 locked stop gives pulse", wdt_rst_req, 1'b1);
        run_count(1, p);
        chk("R8 pulse ends", p, 0);
        do_reset();
        chk("R1 reset clears lock", reg_rdata, 8'h3F);
    endtask

    task automatic t_long_range();
        int p;
        do_reset();
        do_write(8'h00);
        run_count(2048, p);
        chk("R6 high stepped per low wrap", reg_rdata, 8'h3E);
        chk("R4 no pulse yet", p, 0);
        run_count(131071 - 2048, p);
        chk("R6 no early pulse", p, 0);
        run_count(1, p);
        chk("R6 pulse at 131072", p, 1);
    endtask

    initial begin
        t_reset_state();
        t_stopped();
        t_stop_unlocked();
        t_short_range();
        t_kick();
        t_lock();
        t_long_range();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule